// File: doc/BRIEF.md
# DRAM Cache-Line Fill Sequencer

This block sits between a cache and one rank of DRAM. Each cache-line request, read or write, becomes a fixed three-command sequence on the request's bank: open the row, run one column burst of eight beats, then close the row. The rank is eight byte-wide devices working in lockstep, so each beat is 64 bits and one burst moves exactly one 64-byte line. Read beats are gathered into a 512-bit line and handed back with the request's tag. A write line is taken whole when the request is accepted and is sent out as eight ascending beats.

Every bank has its own small state machine and its own down-counter for the minimum spacing between its commands. Banks therefore make progress independently, and the command bus is shared among them by a round-robin picker that issues at most one command per clock. One burst engine owns the data bus, so column commands are serialised. All other command types overlap freely across banks.

Top module: `line_fill_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, cmd_cs_n is 1, cmd_code is NOP (0), req_ready is 1 for any address, rd_valid is 0 and dq_oe is 0.
- R2: The request address is req_addr = {row, bank, line column}, with a 14-bit row, a 3-bit bank and a 7-bit line column. Each accepted request issues exactly three commands on its bank, in this order: ACT carrying the row, then RD for a read or WR for a write with cmd_col = {line column, 3'b000}, then PRE.
- R3: On one bank, ACT and the column command that follows it are at least T_RCD cycles apart. The column command and the PRE after it are at least T_CL+8+T_RTP cycles apart for a read and T_CL+8+T_WR for a write. A PRE and the next ACT are at least T_RP cycles apart.
- R4: At most one command is issued per cycle. cmd_cs_n is 0 exactly in the cycles whose cmd_code is not NOP. The command codes are NOP=0, ACT=1, RD=2, WR=3 and PRE=4.
- R5: If a RD is on the bus in cycle t, read beat i is sampled from dq_in in cycle t+T_CL+i. That beat lands in rd_line bits [64i+63:64i]. rd_valid is high only in cycle t+T_CL+8, for one cycle, and rd_tag then carries that request's tag.
- R6: If a WR is on the bus in cycle t, dq_oe is 1 in cycles t+T_CL to t+T_CL+7, and in cycle t+T_CL+i dq_out holds bits [64i+63:64i] of the write line. dq_oe is 0 in every other cycle.
- R7: req_ready is 0 while the addressed bank holds a request, from acceptance until T_RP cycles after its PRE. A request to an idle bank is accepted while other banks are busy, and its ACT can be issued while another bank still has a row open.
- R8: Any two column commands (RD or WR), on any banks, are at least T_CL+8 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Addressed bank can take the request |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_addr | input | 24 | {row, bank, line column} |
| req_tag | input | 4 | Tag returned with read data |
| req_wdata | input | 512 | Write line, beat 0 in the low 64 bits |
| rd_valid | output | 1 | One-cycle pulse: read line complete |
| rd_tag | output | 4 | Tag of the completed read |
| rd_line | output | 512 | Assembled read line |
| cmd_cs_n | output | 1 | Active-low chip select, shared by the rank |
| cmd_code | output | 3 | Command code |
| cmd_bank | output | 3 | Command bank |
| cmd_row | output | 14 | Row address (ACT) |
| cmd_col | output | 10 | Column address (RD/WR) |
| dq_out | output | 64 | Write beat |
| dq_oe | output | 1 | Write beat driven |
| dq_in | input | 64 | Read beat from the rank |

## Verification
The bench first sends isolated reads and then isolated writes to each of the eight banks. These runs check the command order, the address fields and the beat timing without any contention. Next it sends eight reads back to back to eight different banks, which shows whether the banks really overlap and whether the shared data bus is kept to one burst at a time. Repeated requests to a single bank show that acceptance waits until that bank has finished precharging. A mixed read/write sweep at the extreme row and column values catches swapped or truncated address fields, and every read beat carries a different pattern, so a misplaced beat shows up in the line.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  localparam int BEAT_W = 64;
  localparam int BURST  = 8;
  localparam int LINE_W = BEAT_W * BURST;

  typedef enum logic [2:0] {
    C_NOP = 3'd0,
    C_ACT = 3'd1,
    C_RD  = 3'd2,
    C_WR  = 3'd3,
    C_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE,
    B_ACT,
    B_OPEN,
    B_ACC,
    B_CLOSE
  } bst_e;
endpackage

// File: rtl/lfs_bank.sv
module lfs_bank
  import lfs_pkg::*;
#(
  parameter int ROW_W  = 14,
  parameter int LCOL_W = 7,
  parameter int TAG_W  = 4,
  parameter int T_RCD  = 3,
  parameter int PRE_RD = 14,
  parameter int PRE_WR = 15,
  parameter int T_RP   = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              ld_wr,
  input  logic [ROW_W-1:0]  ld_row,
  input  logic [LCOL_W-1:0] ld_lcol,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic              col_ok,
  input  logic              grant,
  output logic              idle,
  output logic              want,
  output logic [2:0]        want_cmd,
  output logic [ROW_W-1:0]  row,
  output logic [LCOL_W-1:0] lcol,
  output logic [TAG_W-1:0]  tag
);
  bst_e             st;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;

  assign idle = (st == B_IDLE);

  always_comb begin
    want     = 1'b0;
    want_cmd = C_NOP;
    unique case (st)
      B_ACT:  begin want = 1'b1; want_cmd = C_ACT; end
      B_OPEN: begin want = (cnt == '0) && col_ok; want_cmd = wr_q ? C_WR : C_RD; end
      B_ACC:  begin want = (cnt == '0); want_cmd = C_PRE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= B_IDLE;
      cnt <= '0;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      unique case (st)
        B_IDLE:  if (load) st <= B_ACT;
        B_ACT:   if (grant) begin st <= B_OPEN; cnt <= CNT_W'(T_RCD - 1); end
        B_OPEN:  if (grant) begin
                   st  <= B_ACC;
                   cnt <= wr_q ? CNT_W'(PRE_WR - 1) : CNT_W'(PRE_RD - 1);
                 end
        B_ACC:   if (grant) begin st <= B_CLOSE; cnt <= CNT_W'(T_RP - 1); end
        B_CLOSE: if (cnt == '0) st <= B_IDLE;
        default: st <= B_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (load && idle) begin
      wr_q <= ld_wr;
      row  <= ld_row;
      lcol <= ld_lcol;
      tag  <= ld_tag;
    end
  end

  // checker: cycles since this bank's ACT was granted
  logic [CNT_W-1:0] since_act;
  always_ff @(posedge clk) begin
    if (rst) since_act <= '1;
    else if (grant && st == B_ACT) since_act <= '0;
    else if (since_act != '1) since_act <= since_act + 1'b1;
  end

  p_grant_wanted_r2: assert property (@(posedge clk) disable iff (rst)
    grant |-> want);
  p_act_to_col_r3: assert property (@(posedge clk) disable iff (rst)
    (grant && st == B_OPEN) |-> (since_act >= CNT_W'(T_RCD - 1)));
  p_busy_after_load_r7: assert property (@(posedge clk) disable iff (rst)
    (load && idle) |=> !idle);
endmodule

// File: rtl/lfs_rr_arb.sv
module lfs_rr_arb #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any
);
  logic [IDX_W-1:0] ptr;

  always_comb begin
    any     = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[(int'(ptr) + k) % N]) begin
        any     = 1'b1;
        gnt_idx = IDX_W'((int'(ptr) + k) % N);
      end
    end
    gnt = any ? (N'(1) << gnt_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (any) ptr <= (gnt_idx == IDX_W'(N - 1)) ? '0 : gnt_idx + 1'b1;
  end

  p_grant_live_r4: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> any);
endmodule

// File: rtl/lfs_burst.sv
module lfs_burst
  import lfs_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int T_CL  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              fire_wr,
  input  logic [TAG_W-1:0]  fire_tag,
  input  logic [LINE_W-1:0] wline,
  input  logic [BEAT_W-1:0] dq_in,
  output logic              busy,
  output logic [BEAT_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line
);
  localparam int LAST = T_CL + BURST - 1;
  localparam int PH_W = $clog2(LAST + 2);

  logic [PH_W-1:0]   ph;
  logic              wr_q;
  logic [2:0]        wbeat, rbeat;
  logic              w_win, r_win;
  logic [BEAT_W-1:0] rmem [BURST];

  assign wbeat = 3'(ph - PH_W'(T_CL - 1));
  assign rbeat = 3'(ph - PH_W'(T_CL));
  assign w_win = busy && wr_q && (ph >= PH_W'(T_CL - 1)) && (ph < PH_W'(LAST));
  assign r_win = busy && !wr_q && (ph >= PH_W'(T_CL)) && (ph <= PH_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ph       <= '0;
      wr_q     <= 1'b0;
      rd_tag   <= '0;
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      dq_oe    <= w_win;
      if (w_win) dq_out <= wline[{wbeat, 6'b0} +: BEAT_W];
      if (fire) begin
        busy   <= 1'b1;
        ph     <= '0;
        wr_q   <= fire_wr;
        rd_tag <= fire_tag;
      end else if (busy) begin
        ph <= ph + 1'b1;
        if (ph == PH_W'(LAST)) begin
          busy     <= 1'b0;
          rd_valid <= !wr_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (r_win) rmem[rbeat] <= dq_in;
  end

  for (genvar g = 0; g < BURST; g++) begin : g_line
    assign rd_line[g*BEAT_W +: BEAT_W] = rmem[g];
  end

  p_one_burst_r8: assert property (@(posedge clk) disable iff (rst)
    fire |-> !busy);
  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  p_oe_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(busy));
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
  import lfs_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int TAG_W = 4,
  parameter int T_RCD = 3,
  parameter int T_CL  = 4,
  parameter int T_RTP = 2,
  parameter int T_WR  = 3,
  parameter int T_RP  = 3,
  localparam int BANK_W = $clog2(NBANK),
  localparam int LCOL_W = COL_W - $clog2(BURST),
  localparam int ADDR_W = ROW_W + BANK_W + LCOL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  output logic              cmd_cs_n,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [BEAT_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [BEAT_W-1:0] dq_in
);
  localparam int PRE_RD  = T_CL + BURST + T_RTP;
  localparam int PRE_WR  = T_CL + BURST + T_WR;
  localparam int MAX_GAP = (PRE_RD > PRE_WR) ? PRE_RD : PRE_WR;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  logic [ROW_W-1:0]  a_row;
  logic [BANK_W-1:0] a_bank;
  logic [LCOL_W-1:0] a_lcol;
  logic              accept;

  assign a_lcol = req_addr[LCOL_W-1:0];
  assign a_bank = req_addr[LCOL_W +: BANK_W];
  assign a_row  = req_addr[ADDR_W-1 -: ROW_W];

  logic [NBANK-1:0]  b_idle, b_want, b_gnt;
  logic [2:0]        b_cmd  [NBANK];
  logic [ROW_W-1:0]  b_row  [NBANK];
  logic [LCOL_W-1:0] b_lcol [NBANK];
  logic [TAG_W-1:0]  b_tag  [NBANK];
  logic              eng_busy;

  assign req_ready = b_idle[a_bank];
  assign accept    = req_valid && req_ready;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    lfs_bank #(
      .ROW_W(ROW_W), .LCOL_W(LCOL_W), .TAG_W(TAG_W), .T_RCD(T_RCD),
      .PRE_RD(PRE_RD), .PRE_WR(PRE_WR), .T_RP(T_RP), .CNT_W(CNT_W)
    ) u_bank (
      .clk(clk), .rst(rst),
      .load(accept && (a_bank == BANK_W'(g))),
      .ld_wr(req_write), .ld_row(a_row), .ld_lcol(a_lcol), .ld_tag(req_tag),
      .col_ok(!eng_busy), .grant(b_gnt[g]),
      .idle(b_idle[g]), .want(b_want[g]), .want_cmd(b_cmd[g]),
      .row(b_row[g]), .lcol(b_lcol[g]), .tag(b_tag[g])
    );
  end

  logic [BANK_W-1:0] gnt_idx;
  logic              gnt_any;

  lfs_rr_arb #(.N(NBANK), .IDX_W(BANK_W)) u_arb (
    .clk(clk), .rst(rst), .req(b_want), .gnt(b_gnt), .gnt_idx(gnt_idx), .any(gnt_any)
  );

  cmd_e g_cmd;
  logic col_fire;
  assign g_cmd    = cmd_e'(b_cmd[gnt_idx]);
  assign col_fire = gnt_any && (g_cmd == C_RD || g_cmd == C_WR);

  // per-bank write line store: one write port, one registered read port
  logic [LINE_W-1:0] wbuf [NBANK];
  logic [LINE_W-1:0] wsel_q;

  always_ff @(posedge clk) begin
    if (accept && req_write) wbuf[a_bank] <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (col_fire) wsel_q <= wbuf[gnt_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_cs_n <= 1'b1;
      cmd_code <= C_NOP;
      cmd_bank <= '0;
      cmd_row  <= '0;
      cmd_col  <= '0;
    end else if (gnt_any) begin
      cmd_cs_n <= 1'b0;
      cmd_code <= g_cmd;
      cmd_bank <= gnt_idx;
      cmd_row  <= b_row[gnt_idx];
      cmd_col  <= {b_lcol[gnt_idx], {(COL_W - LCOL_W){1'b0}}};
    end else begin
      cmd_cs_n <= 1'b1;
      cmd_code <= C_NOP;
    end
  end

  lfs_burst #(.TAG_W(TAG_W), .T_CL(T_CL)) u_burst (
    .clk(clk), .rst(rst),
    .fire(col_fire), .fire_wr(g_cmd == C_WR), .fire_tag(b_tag[gnt_idx]),
    .wline(wsel_q), .dq_in(dq_in),
    .busy(eng_busy), .dq_out(dq_out), .dq_oe(dq_oe),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_line(rd_line)
  );

  p_select_with_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    (!cmd_cs_n) |-> (cmd_code != C_NOP));
  p_nop_deselect_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_cs_n) |-> (cmd_code == C_NOP));
  p_col_when_free_r8: assert property (@(posedge clk) disable iff (rst)
    col_fire |-> !eng_busy);
endmodule

// File: tb/line_fill_seq_tb.sv
module line_fill_seq_tb;
  localparam int NB = 8, ROW_W = 14, COL_W = 10, TAG_W = 4, LCOL_W = 7;
  localparam int T_RCD = 3, T_CL = 4, T_RTP = 2, T_WR = 3, T_RP = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [511:0] req_wdata = '0;
  logic req_ready, rd_valid, cmd_cs_n, dq_oe;
  logic [TAG_W-1:0] rd_tag;
  logic [511:0] rd_line;
  logic [2:0] cmd_code, cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [63:0] dq_out;
  logic [63:0] dq_in = '0;

  line_fill_seq #(.NBANK(NB), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W), .T_RCD(T_RCD),
    .T_CL(T_CL), .T_RTP(T_RTP), .T_WR(T_WR), .T_RP(T_RP)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_tag(req_tag), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_tag(rd_tag), .rd_line(rd_line), .cmd_cs_n(cmd_cs_n), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, ovl = 0, last_col = -1000;
  int phase [NB], t_act [NB], t_col [NB], t_pre [NB];
  int e_row [NB], e_lcol [NB], e_tag [NB];
  bit e_wr [NB];
  logic [511:0] e_line [NB];
  bit bact = 1'b0, bwr = 1'b0;
  int bst = 0, bbank = 0, btag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] rpat(input int b, input int r, input int c, input int i);
    return {8'(b), 8'(i), 16'(r), 16'(c), 16'(16'hA5C3 ^ (i * 37))};
  endfunction

  function automatic logic [511:0] rline(input int b, input int r, input int c);
    logic [511:0] l;
    for (int i = 0; i < 8; i++) l[i*64 +: 64] = rpat(b, r, c, i);
    return l;
  endfunction

  function automatic logic [511:0] wline(input int seed);
    logic [511:0] l;
    for (int i = 0; i < 8; i++) l[i*64 +: 64] = {32'(seed), 32'(i) * 32'h9E3779B9 ^ 32'(seed)};
    return l;
  endfunction

  function automatic bit all_quiet();
    for (int b = 0; b < NB; b++) if (phase[b] != 0) return 1'b0;
    return !bact;
  endfunction

  // rank model and command-bus monitor
  always @(negedge clk) begin
    if (!rst) begin
      chk(cmd_cs_n == (cmd_code == 3'd0), "R4 select vs code", {cmd_cs_n, cmd_code}, 0);
      if (!cmd_cs_n) begin
        int b;
        b = int'(cmd_bank);
        case (cmd_code)
          3'd1: begin
            chk(phase[b] == 1, "R2 ACT order", phase[b], 1);
            chk(cmd_row == ROW_W'(e_row[b]), "R2 ACT row", cmd_row, e_row[b]);
            chk(cyc - t_pre[b] >= T_RP, "R3 PRE to ACT", cyc - t_pre[b], T_RP);
            for (int o = 0; o < NB; o++) if (o != b && (phase[o] == 2 || phase[o] == 3)) ovl++;
            phase[b] = 2; t_act[b] = cyc;
          end
          3'd2, 3'd3: begin
            chk(phase[b] == 2, "R2 column order", phase[b], 2);
            chk((cmd_code == 3'd3) == e_wr[b], "R2 column kind", cmd_code, e_wr[b] ? 3 : 2);
            chk(cmd_col == {LCOL_W'(e_lcol[b]), 3'b000}, "R2 column address", cmd_col, e_lcol[b] * 8);
            chk(cyc - t_act[b] >= T_RCD, "R3 ACT to column", cyc - t_act[b], T_RCD);
            chk(cyc - last_col >= T_CL + 8, "R8 column spacing", cyc - last_col, T_CL + 8);
            last_col = cyc; phase[b] = 3; t_col[b] = cyc;
            bact = 1'b1; bwr = e_wr[b]; bst = cyc; bbank = b; btag = e_tag[b];
          end
          3'd4: begin
            chk(phase[b] == 3, "R2 PRE order", phase[b], 3);
            chk(cyc - t_col[b] >= T_CL + 8 + (e_wr[b] ? T_WR : T_RTP), "R3 column to PRE",
                cyc - t_col[b], T_CL + 8 + (e_wr[b] ? T_WR : T_RTP));
            phase[b] = 0; t_pre[b] = cyc;
          end
          default: chk(1'b0, "R4 code", cmd_code, 0);
        endcase
      end
      begin
        int d;
        bit rexp;
        d = cyc - bst;
        dq_in = '0;
        if (bact && !bwr && d >= T_CL && d < T_CL + 8)
          dq_in = rpat(bbank, e_row[bbank], e_lcol[bbank], d - T_CL);
        if (bact && bwr && d >= T_CL && d < T_CL + 8) begin
          chk(dq_oe && dq_out == e_line[bbank][(d - T_CL)*64 +: 64], "R6 write beat",
              {dq_oe, dq_out}, {1'b1, e_line[bbank][(d - T_CL)*64 +: 64]});
        end else if (dq_oe) chk(1'b0, "R6 stray drive", dq_oe, 0);
        rexp = bact && !bwr && d == T_CL + 8;
        if (rexp || rd_valid)
          chk(rd_valid && rexp && rd_tag == TAG_W'(btag) &&
              rd_line == rline(bbank, e_row[bbank], e_lcol[bbank]),
              "R5 read line", {rd_valid, rd_tag, rd_line}, {rexp, 4'(btag), rline(bbank, e_row[bbank], e_lcol[bbank])});
        if (bact && d >= T_CL + 8) bact = 1'b0;
      end
    end
  end

  task automatic send(input int b, input int r, input int c, input bit w, input int t);
    req_addr  = {ROW_W'(r), 3'(b), LCOL_W'(c)};
    req_write = w; req_tag = TAG_W'(t); req_wdata = wline(b * 4096 + r + t);
    req_valid = 1'b1;
    #1;
    forever begin
      chk(req_ready == (phase[b] == 0 && cyc >= t_pre[b] + T_RP), "R7 ready per bank",
          req_ready, (phase[b] == 0 && cyc >= t_pre[b] + T_RP));
      if (req_ready) break;
      @(negedge clk); #1;
    end
    @(posedge clk);
    phase[b] = 1; e_row[b] = r; e_lcol[b] = c; e_wr[b] = w; e_tag[b] = t;
    e_line[b] = req_wdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (!all_quiet() || n < 4) begin
      @(negedge clk);
      if (all_quiet()) n++; else n = 0;
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      phase[b] = 0; t_pre[b] = -1000; t_act[b] = -1000; t_col[b] = -1000;
      e_row[b] = 0; e_lcol[b] = 0; e_tag[b] = 0; e_wr[b] = 0; e_line[b] = '0;
    end
    repeat (3) @(negedge clk);
    chk(cmd_cs_n && cmd_code == 0 && !rd_valid && !dq_oe && req_ready, "R1 in reset",
        {cmd_cs_n, cmd_code, rd_valid, dq_oe, req_ready}, 6'b100001);
    @(posedge clk); rst = 1'b0;
    @(negedge clk);
    chk(cmd_cs_n && cmd_code == 0 && !rd_valid && !dq_oe && req_ready, "R1 after reset",
        {cmd_cs_n, cmd_code, rd_valid, dq_oe, req_ready}, 6'b100001);
    // isolated reads then isolated writes, one per bank (R2 R3 R5 R6)
    for (int b = 0; b < NB; b++) begin send(b, b * 3 + 1, b, 1'b0, b); drain(); end
    for (int b = 0; b < NB; b++) begin send(b, 100 + b, 127 - b, 1'b1, b + 8); drain(); end
    // reads to all banks back to back: overlap (R7) and one burst at a time (R8)
    ovl = 0;
    for (int b = 0; b < NB; b++) send(b, 500 + b, 3 * b, 1'b0, 15 - b);
    drain();
    chk(ovl > 0, "R7 bank overlap", ovl, 1);
    // repeated requests to one bank (R7)
    send(2, 7, 9, 1'b0, 1);
    send(2, 7, 10, 1'b1, 2);
    send(2, 8, 9, 1'b0, 3);
    drain();
    // mixed sweep at address extremes (R2 R5 R6)
    for (int i = 0; i < 24; i++)
      send((i * 3) % NB, (i % 2) ? 16383 : 0, (i % 4 < 2) ? 127 : 0, i[0] ^ i[2], i % 16);
    drain();
    for (int b = 0; b < NB; b++) chk(phase[b] == 0, "R2 all sequences closed", phase[b], 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule